// File: doc/BRIEF.md
# Paired Single-Site Spin Update Cells with Shared Threshold Table

This block holds two update cells for a three-dimensional lattice of two-state spins on a Monte Carlo engine. Each cell decides the next value of one site. It uses the site's six nearest neighbours, the six bond couplings to them, an optional site field, the site and neighbour occupancy bits, the present spin and a 32-bit random word. Lattice storage and random word generation sit outside the block. On every cycle with `in_valid` high, the block takes one decision per cell. It returns both new spins one clock later, with `out_valid`.

Each cell reduces the local energy to a small table index. Every one of its seven energy terms scores 0, 1 or 2, and the index is the sum of those scores. The six bonds are terms, and the field counts as a seventh bond to a fixed spin of its sign. The index selects one 32-bit threshold in a 16-entry table. The two cells share this table, and a host port loads it. The new spin then follows from a single unsigned comparison of the random word against the threshold. A mode input chooses the rule. In Metropolis mode the cell decides whether to flip the present spin. In heat-bath mode it picks the new spin directly, from the index computed as if the spin pointed up.

Top module: `ising_cell_pair`

## Requirements
- R1: While reset is asserted and in the cycles that follow its release, `out_valid` is 0 and both bits of `new_spin` are 0.
- R2: `out_valid` equals `in_valid` of the previous cycle. `new_spin` changes only on an edge where `in_valid` was high; otherwise it holds its value.
- R3: Spins and couplings are one bit each (1 means +1, 0 means -1). The cell uses a reference spin s: the old spin in Metropolis mode, or 1 in heat-bath mode. Each bond b scores 1 if its neighbour is unoccupied (`nbr_live` bit 0). Otherwise it scores 2 when s XOR neighbour XOR coupling is 1 (a satisfied bond), and 0 when it is not. The field term scores 1 when `fld_en` is 0, 2 when s equals `fld_sign`, and 0 when it differs. The table index is the sum of the seven scores, from 0 to 14. Cell c uses bits [6c+5:6c] of the neighbour vectors, bits [32c+31:32c] of `rand_word` and bit c of the per-cell inputs.
- R4: Metropolis mode (`upd_heatbath` = 0), occupied site: an index below 7 (a flip that lowers the energy) always flips the spin. Any other index flips it only when the random word is below the selected threshold; otherwise the old spin is kept.
- R5: Heat-bath mode (`upd_heatbath` = 1), occupied site: the new spin is 1 exactly when the random word is below the threshold at the index formed with s = 1, and 0 otherwise. The old spin has no effect.
- R6: A table write on an edge stores the data at its address. That value is used first by the decision whose inputs are sampled on the next edge; a decision sampled on the same edge as the write uses the previous content. Reset clears every entry to 0.
- R7: The two cells read the shared table at their own indices in the same cycle, and each decision depends only on that cell's inputs.
- R8: The comparison is strict and unsigned. A random word equal to the threshold rejects the flip (Metropolis) or gives spin 0 (heat-bath).
- R9: A cell whose site is unoccupied (`site_live` bit 0) returns its old spin in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| thr_wr_en | input | 1 | Threshold table write strobe |
| thr_wr_addr | input | 4 | Threshold entry to write |
| thr_wr_data | input | 32 | Threshold value to write |
| upd_heatbath | input | 1 | 0 selects Metropolis, 1 selects heat-bath |
| in_valid | input | 1 | Cell inputs carry a site to decide this cycle |
| old_spin | input | 2 | Present spin of each cell's site |
| site_live | input | 2 | Occupancy of each cell's site |
| nbr_spin | input | 12 | Six neighbour spins per cell |
| nbr_live | input | 12 | Six neighbour occupancy bits per cell |
| bond_cpl | input | 12 | Six bond couplings per cell |
| fld_en | input | 2 | Field term present for each cell |
| fld_sign | input | 2 | Field sign for each cell |
| rand_word | input | 64 | One 32-bit random word per cell |
| out_valid | output | 1 | `new_spin` holds a fresh decision |
| new_spin | output | 2 | Decided spin of each cell |

## Verification
Directed patterns set the index by hand. Uniformly satisfied bonds reach the top index, uniformly unsatisfied bonds the bottom, and fully unoccupied neighbourhoods land on the neutral index 7; this separates the bond and field scoring from the downhill shortcut. Random words set one below and exactly on a threshold tell strict from non-strict comparison. Heat-bath runs repeat one neighbourhood with both old spins to show the old spin is ignored. A table write placed in the same cycle as a decision that reads it shows the write-to-use latency. Long random runs mix occupancy, fields, modes, idle cycles and table rewrites, checking both cells against a behavioural model on every clock.

// File: rtl/ising_cell_pkg.sv
`timescale 1ns/1ps
package ising_cell_pkg;

  // Selection of the update rule.
  typedef enum logic {
    UPD_METRO    = 1'b0,
    UPD_HEATBATH = 1'b1
  } upd_mode_e;

  // Contribution of one energy term to the table index.
  typedef enum logic [1:0] {
    SC_UNSAT = 2'd0,
    SC_OPEN  = 2'd1,
    SC_SAT   = 2'd2
  } term_score_e;

  function automatic term_score_e score_term(input logic active, input logic agree);
    if (!active) begin
      return SC_OPEN;
    end else if (agree) begin
      return SC_SAT;
    end else begin
      return SC_UNSAT;
    end
  endfunction

endpackage

// File: rtl/isc_threshold_table.sv
`timescale 1ns/1ps
module isc_threshold_table #(
  parameter int AW  = 4,
  parameter int DW  = 32,
  parameter int NRD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic [NRD*DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] ent_we;

  // Write decode: one clock enable per entry.
  always_comb begin
    ent_we = '0;
    if (wr_en) begin
      ent_we[wr_addr] = 1'b1;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[e] <= '0;
      end else if (ent_we[e]) begin
        mem_q[e] <= wr_data;
      end
    end
  end

  // Combinational read ports, one per sharing cell.
  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r*DW +: DW] = mem_q[rd_addr[r*AW +: AW]];
  end

  // R6: a written value is present in its entry after the edge.
  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/isc_local_index.sv
`timescale 1ns/1ps
module isc_local_index
  import ising_cell_pkg::*;
#(
  parameter int NB = 6,
  parameter int IW = 4
) (
  input  logic          s_ref,
  input  logic [NB-1:0] nbr_spin,
  input  logic [NB-1:0] nbr_live,
  input  logic [NB-1:0] bond_cpl,
  input  logic          fld_en,
  input  logic          fld_sign,
  output logic [IW-1:0] idx
);

  term_score_e bond_sc [NB];
  term_score_e field_sc;

  // A bond is satisfied when the product of its three signs is +1.
  for (genvar b = 0; b < NB; b++) begin : g_bond
    assign bond_sc[b] = score_term(nbr_live[b], s_ref ^ nbr_spin[b] ^ bond_cpl[b]);
  end

  // The field acts as one more bond to a fixed spin of its sign.
  assign field_sc = score_term(fld_en, ~(s_ref ^ fld_sign));

  always_comb begin
    logic [IW-1:0] acc;
    acc = IW'(field_sc);
    for (int i = 0; i < NB; i++) begin
      acc = acc + IW'(bond_sc[i]);
    end
    idx = acc;
  end

endmodule

// File: rtl/isc_spin_decide.sv
`timescale 1ns/1ps
module isc_spin_decide
  import ising_cell_pkg::*;
#(
  parameter int NB = 6,
  parameter int IW = 4,
  parameter int RW = 32
) (
  input  upd_mode_e     mode,
  input  logic          site_live,
  input  logic          old_spin,
  input  logic [IW-1:0] idx,
  input  logic [RW-1:0] thr,
  input  logic [RW-1:0] rnd,
  output logic          nxt_spin
);

  // Index of a flip that leaves the energy unchanged.
  localparam int NEUTRAL = NB + 1;

  logic below;
  logic downhill;

  assign below    = rnd < thr;
  assign downhill = idx < IW'(NEUTRAL);

  always_comb begin
    nxt_spin = old_spin;
    if (site_live) begin
      unique case (mode)
        UPD_METRO:    nxt_spin = (downhill || below) ? ~old_spin : old_spin;
        UPD_HEATBATH: nxt_spin = below;
        default:      nxt_spin = old_spin;
      endcase
    end
  end

endmodule

// File: rtl/ising_cell_pair.sv
`timescale 1ns/1ps
module ising_cell_pair
  import ising_cell_pkg::*;
#(
  parameter int NCELL = 2,
  parameter int NB    = 6,
  parameter int RW    = 32,
  parameter int AW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                thr_wr_en,
  input  logic [AW-1:0]       thr_wr_addr,
  input  logic [RW-1:0]       thr_wr_data,
  input  logic                upd_heatbath,
  input  logic                in_valid,
  input  logic [NCELL-1:0]    old_spin,
  input  logic [NCELL-1:0]    site_live,
  input  logic [NCELL*NB-1:0] nbr_spin,
  input  logic [NCELL*NB-1:0] nbr_live,
  input  logic [NCELL*NB-1:0] bond_cpl,
  input  logic [NCELL-1:0]    fld_en,
  input  logic [NCELL-1:0]    fld_sign,
  input  logic [NCELL*RW-1:0] rand_word,
  output logic                out_valid,
  output logic [NCELL-1:0]    new_spin
);

  localparam int IW      = AW;
  localparam int MAX_IDX = 2 * (NB + 1);
  localparam int NEUTRAL = NB + 1;

  // Reset: asserted at once, released after two clocks.
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  upd_mode_e          mode;
  logic [NCELL*IW-1:0] idx_bus;
  logic [NCELL*RW-1:0] thr_bus;
  logic [NCELL-1:0]    nxt_spin;

  assign mode = upd_mode_e'(upd_heatbath);

  isc_threshold_table #(
    .AW  (AW),
    .DW  (RW),
    .NRD (NCELL)
  ) u_tbl (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (thr_wr_en),
    .wr_addr (thr_wr_addr),
    .wr_data (thr_wr_data),
    .rd_addr (idx_bus),
    .rd_data (thr_bus)
  );

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    logic          s_ref;
    logic [IW-1:0] cell_idx;
    logic [RW-1:0] cell_thr;

    // Heat-bath evaluates the energy with the site pointing up.
    assign s_ref    = (mode == UPD_HEATBATH) ? 1'b1 : old_spin[c];
    assign idx_bus[c*IW +: IW] = cell_idx;
    assign cell_thr = thr_bus[c*RW +: RW];

    isc_local_index #(
      .NB (NB),
      .IW (IW)
    ) u_idx (
      .s_ref    (s_ref),
      .nbr_spin (nbr_spin[c*NB +: NB]),
      .nbr_live (nbr_live[c*NB +: NB]),
      .bond_cpl (bond_cpl[c*NB +: NB]),
      .fld_en   (fld_en[c]),
      .fld_sign (fld_sign[c]),
      .idx      (cell_idx)
    );

    isc_spin_decide #(
      .NB (NB),
      .IW (IW),
      .RW (RW)
    ) u_dec (
      .mode      (mode),
      .site_live (site_live[c]),
      .old_spin  (old_spin[c]),
      .idx       (cell_idx),
      .thr       (cell_thr),
      .rnd       (rand_word[c*RW +: RW]),
      .nxt_spin  (nxt_spin[c])
    );

    // R3: the index never leaves the range of seven ternary terms.
    p_index_bound_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
      cell_idx <= IW'(MAX_IDX));

    // R9: an unoccupied site returns its old spin.
    p_dead_site_keeps_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
      (in_valid && !site_live[c]) |=> new_spin[c] == $past(old_spin[c]));

    // R4: a downhill Metropolis move always flips.
    p_downhill_flips_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
      (in_valid && site_live[c] && !upd_heatbath && cell_idx < IW'(NEUTRAL))
        |=> new_spin[c] != $past(old_spin[c]));

    // R8: a random word equal to the threshold never flips in Metropolis.
    p_equal_rejects_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
      (in_valid && site_live[c] && !upd_heatbath && cell_idx >= IW'(NEUTRAL)
        && rand_word[c*RW +: RW] == cell_thr) |=> new_spin[c] == $past(old_spin[c]));
  end

  // Output stage: next-state then register.
  logic [NCELL-1:0] spin_d;
  logic             valid_d;

  always_comb begin
    valid_d = in_valid;
    spin_d  = new_spin;
    if (in_valid) begin
      spin_d = nxt_spin;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      out_valid <= 1'b0;
      new_spin  <= '0;
    end else begin
      out_valid <= valid_d;
      new_spin  <= spin_d;
    end
  end

  // R2: valid follows the input by one cycle; idle cycles hold the spins.
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    in_valid |=> out_valid);
  p_idle_clears_valid_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_valid |=> !out_valid);
  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_valid |=> $stable(new_spin));

endmodule

// File: tb/sim_ising_cell_pair.sv
`timescale 1ns/1ps
module sim_ising_cell_pair;

  localparam int NC = 2;
  localparam int NB = 6;
  localparam int RW = 32;
  localparam int AW = 4;

  logic            clk;
  logic            rst_n;
  logic            thr_wr_en;
  logic [AW-1:0]   thr_wr_addr;
  logic [RW-1:0]   thr_wr_data;
  logic            upd_heatbath;
  logic            in_valid;
  logic [NC-1:0]   old_spin;
  logic [NC-1:0]   site_live;
  logic [NC*NB-1:0] nbr_spin;
  logic [NC*NB-1:0] nbr_live;
  logic [NC*NB-1:0] bond_cpl;
  logic [NC-1:0]   fld_en;
  logic [NC-1:0]   fld_sign;
  logic [NC*RW-1:0] rand_word;
  logic            out_valid;
  logic [NC-1:0]   new_spin;

  ising_cell_pair #(.NCELL(NC), .NB(NB), .RW(RW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .thr_wr_en(thr_wr_en), .thr_wr_addr(thr_wr_addr), .thr_wr_data(thr_wr_data),
    .upd_heatbath(upd_heatbath), .in_valid(in_valid),
    .old_spin(old_spin), .site_live(site_live),
    .nbr_spin(nbr_spin), .nbr_live(nbr_live), .bond_cpl(bond_cpl),
    .fld_en(fld_en), .fld_sign(fld_sign), .rand_word(rand_word),
    .out_valid(out_valid), .new_spin(new_spin)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk;
  int n_fail;
  int cyc;
  logic [RW-1:0] model_tbl [16];
  logic          exp_valid;
  logic [NC-1:0] exp_spin;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: cycles %0d expected at most %0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  // Behavioural model of one cell decision (R3, R4, R5, R8, R9).
  function automatic logic ref_cell(int k);
    logic s;
    int   t;
    logic [RW-1:0] r;
    s = upd_heatbath ? 1'b1 : old_spin[k];
    r = rand_word[k*RW +: RW];
    t = 0;
    for (int b = 0; b < NB; b++) begin
      if (!nbr_live[k*NB+b]) t += 1;
      else if ((s ^ nbr_spin[k*NB+b] ^ bond_cpl[k*NB+b]) == 1'b1) t += 2;
    end
    if (!fld_en[k]) t += 1;
    else if (s == fld_sign[k]) t += 2;
    if (!site_live[k]) return old_spin[k];
    if (!upd_heatbath) begin
      if (t < NB + 1) return ~old_spin[k];
      return (r < model_tbl[t]) ? ~old_spin[k] : old_spin[k];
    end
    return (r < model_tbl[t]) ? 1'b1 : 1'b0;
  endfunction

  // Applies the driven inputs for one clock and compares the result.
  task automatic tick(input string tag);
    exp_valid = in_valid;
    if (in_valid) begin
      for (int k = 0; k < NC; k++) exp_spin[k] = ref_cell(k);
    end
    if (thr_wr_en) model_tbl[thr_wr_addr] = thr_wr_data;
    @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (out_valid !== exp_valid || new_spin !== exp_spin) begin
      n_fail++;
      $display("FAIL %s: valid/spin actual %b/%b expected %b/%b",
               tag, out_valid, new_spin, exp_valid, exp_spin);
    end
  endtask

  task automatic put_cell(input int k, input logic old, input logic live,
                          input logic [NB-1:0] ns, input logic [NB-1:0] nl,
                          input logic [NB-1:0] cp, input logic fe, input logic fs,
                          input logic [RW-1:0] r);
    old_spin[k]  = old;
    site_live[k] = live;
    nbr_spin[k*NB +: NB] = ns;
    nbr_live[k*NB +: NB] = nl;
    bond_cpl[k*NB +: NB] = cp;
    fld_en[k]   = fe;
    fld_sign[k] = fs;
    rand_word[k*RW +: RW] = r;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0;
    rst_n = 1'b0;
    thr_wr_en = 1'b0; thr_wr_addr = '0; thr_wr_data = '0;
    upd_heatbath = 1'b0; in_valid = 1'b0;
    old_spin = '0; site_live = '0; nbr_spin = '0; nbr_live = '0; bond_cpl = '0;
    fld_en = '0; fld_sign = '0; rand_word = '0;
    for (int i = 0; i < 16; i++) model_tbl[i] = '0;
    exp_valid = 1'b0; exp_spin = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    n_chk++;
    if (out_valid !== 1'b0 || new_spin !== '0) begin
      n_fail++;
      $display("FAIL R1: valid/spin actual %b/%b expected 0/00", out_valid, new_spin);
    end

    // R6: cleared table rejects an uphill move; cell 1 downhill flips (R4)
    in_valid = 1'b1;
    put_cell(0, 1'b1, 1'b1, 6'h3F, 6'h3F, 6'h3F, 1'b1, 1'b1, 32'h0);
    put_cell(1, 1'b0, 1'b1, 6'h3F, 6'h3F, 6'h3F, 1'b1, 1'b1, 32'h0);
    tick("R6");

    // R2: idle cycles while the table is loaded
    in_valid = 1'b0;
    for (int i = 0; i < 16; i++) begin
      thr_wr_en = 1'b1;
      thr_wr_addr = AW'(i);
      thr_wr_data = 32'(i) * 32'h1000_0000 + 32'h0800_0000;
      tick("R2");
    end
    thr_wr_en = 1'b0;

    // R3: all neighbours empty, no field -> index 7; one below threshold flips
    in_valid = 1'b1;
    put_cell(0, 1'b0, 1'b1, 6'h00, 6'h00, 6'h00, 1'b0, 1'b0, 32'h77FF_FFFF);
    put_cell(1, 1'b1, 1'b1, 6'h15, 6'h00, 6'h2A, 1'b0, 1'b1, 32'h77FF_FFFF);
    tick("R3");
    // R8: word equal to the threshold keeps the spin
    rand_word = {32'h7800_0000, 32'h7800_0000};
    tick("R8");

    // R4: downhill flips even with the largest random word
    put_cell(0, 1'b1, 1'b1, 6'h00, 6'h3F, 6'h3F, 1'b0, 1'b0, 32'hFFFF_FFFF);
    put_cell(1, 1'b0, 1'b1, 6'h3F, 6'h3F, 6'h3F, 1'b1, 1'b1, 32'hFFFF_FFFF);
    tick("R4");

    // R7: same random word, different indices per cell (10 and 9)
    put_cell(0, 1'b0, 1'b1, 6'h07, 6'h07, 6'h00, 1'b0, 1'b0, 32'h9800_0000);
    put_cell(1, 1'b0, 1'b1, 6'h03, 6'h03, 6'h00, 1'b0, 1'b0, 32'h9800_0000);
    tick("R7");

    // R9: unoccupied sites keep the old spin
    put_cell(0, 1'b1, 1'b0, 6'h00, 6'h3F, 6'h3F, 1'b0, 1'b0, 32'h0);
    put_cell(1, 1'b0, 1'b0, 6'h3F, 6'h3F, 6'h3F, 1'b1, 1'b1, 32'h0);
    tick("R9");

    // R5: heat-bath, index 13; old spin 0 then 1 gives the same result
    upd_heatbath = 1'b1;
    put_cell(0, 1'b0, 1'b1, 6'h3F, 6'h3F, 6'h3F, 1'b0, 1'b0, 32'hD7FF_FFFF);
    put_cell(1, 1'b0, 1'b1, 6'h3F, 6'h3F, 6'h3F, 1'b0, 1'b0, 32'hD800_0000);
    tick("R5");
    old_spin = 2'b11;
    tick("R5");
    upd_heatbath = 1'b0;

    // R6: write in the same cycle as a read of that entry uses the old value
    put_cell(0, 1'b1, 1'b1, 6'h3F, 6'h3F, 6'h3F, 1'b1, 1'b1, 32'h8000_0000);
    put_cell(1, 1'b1, 1'b1, 6'h3F, 6'h3F, 6'h3F, 1'b1, 1'b1, 32'h8000_0000);
    thr_wr_en = 1'b1; thr_wr_addr = 4'd14; thr_wr_data = 32'h0;
    tick("R6");
    thr_wr_en = 1'b0;
    tick("R6");

    // Random mix of both modes, idle cycles and table rewrites
    for (int n = 0; n < 3000; n++) begin
      if ((n % 50) == 0) upd_heatbath = $urandom_range(0, 1) == 1;
      in_valid  = $urandom_range(0, 4) != 0;
      old_spin  = NC'($urandom);
      site_live = ($urandom_range(0, 5) == 0) ? NC'($urandom) : '1;
      nbr_spin  = (NC*NB)'($urandom);
      nbr_live  = ($urandom_range(0, 2) == 0) ? (NC*NB)'($urandom) : '1;
      bond_cpl  = (NC*NB)'($urandom);
      fld_en    = NC'($urandom);
      fld_sign  = NC'($urandom);
      rand_word = {$urandom, $urandom};
      thr_wr_en = $urandom_range(0, 7) == 0;
      thr_wr_addr = AW'($urandom);
      thr_wr_data = $urandom;
      tick(upd_heatbath ? "R5" : "R4");
    end
    thr_wr_en = 1'b0;
    in_valid  = 1'b0;
    tick("R2");

    summary();
    $finish;
  end

endmodule